// File: doc/BRIEF.md
# Break-Even Task Offload Arbiter

This block takes tasks from a dependence graph one at a time and decides where each one runs. The task can run on the host processor, or it can be offloaded to one of several reconfigurable accelerator units. An external tracker raises a bit in a ready mask once all of a task's predecessors have finished. The block keeps its own record of which tasks it has already completed. From the tasks that are ready and not yet done, it takes the one with the lowest index.

For the chosen task, the block looks up the task's kernel type and that kernel's four cost estimates, all in cycles:
- host run time,
- accelerator run time,
- reconfiguration time,
- communication time.

If any unit already holds the kernel, the reconfiguration term counts as zero. The task is offloaded only when the host time is strictly larger than the total accelerator-side cost.

The block reports each decision as a stream of commands under a valid/ready handshake:
- A host task produces a single host-run command.
- An offloaded task produces an optional configure command, then a send-inputs command, then a fetch-results command.

The block selects no new task until the last command of the current task has been accepted. Two counters keep a running total of host runs and offloads.

Top module: `ko_offload_arbiter`

## Requirements
- R1: A task is a candidate only while its ready_mask_i bit is 1 and it has not been completed. A task becomes completed when its last command (host-run or fetch) is accepted, and it is never issued again.
- R2: Among the candidates, the task with the lowest index is selected.
- R3: A task's kernel is resident when at least one unit's loaded kernel id equals it. For a resident kernel the reconfiguration time adds nothing to the cost, no configure command is issued, and the command unit is the lowest-index unit holding that kernel.
- R4: The task runs on the host when host time <= accelerator + communication + reconfiguration time (the last term counted only when not resident). Otherwise it is offloaded. The sum is formed two bits wider than the timing values, so it never wraps.
- R5: A host task issues exactly one command with cmd_op_o = 0 (host run) carrying its task id. The unit field carries no meaning for this command.
- R6: An offloaded task issues, in this order, cmd_op_o = 1 (configure, only when not resident), 2 (send inputs) and 3 (fetch results). All of its commands carry the same task id and unit.
- R7: For a non-resident kernel the target unit comes from a rotating pointer. The pointer is 0 after reset, steps by one on each accepted configure command, and wraps after the last unit.
- R8: A command is accepted on a cycle where cmd_valid_o and cmd_ready_i are both 1. While cmd_valid_o is 1 and cmd_ready_i is 0, the command's op, task and unit stay unchanged.
- R9: host_cnt_o increments on each accepted host-run command, and offload_cnt_o increments on each accepted fetch command.
- R10: After reset, cmd_valid_o is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_mask_i | input | NUM_TASKS | Tasks whose predecessors have all finished |
| task_kernel_i | input | NUM_TASKS*KW | Kernel id of each task, task i at bits [i*KW +: KW] |
| unit_kernel_i | input | NUM_UNITS*KW | Kernel id loaded in each unit |
| t_host_i | input | NUM_KERNELS*TW | Host run time per kernel |
| t_acc_i | input | NUM_KERNELS*TW | Accelerator run time per kernel |
| t_cfg_i | input | NUM_KERNELS*TW | Reconfiguration time per kernel |
| t_comm_i | input | NUM_KERNELS*TW | Communication time per kernel |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by consumer |
| cmd_op_o | output | 2 | 0 host run, 1 configure, 2 send inputs, 3 fetch results |
| cmd_task_o | output | TIDW | Task id of the command |
| cmd_unit_o | output | UW | Target unit |
| cmd_kernel_o | output | KW | Kernel id of the task |
| offload_o | output | 1 | Current task is offloaded |
| reconf_o | output | 1 | Current task needs a reconfiguration |
| host_cnt_o | output | CW | Host runs completed |
| offload_cnt_o | output | CW | Offloads completed |

## Verification
Two events can fall in the same cycle. A task's last command can be accepted, marking that task completed, while the ready mask gains a new bit that is lower in index than the tasks still waiting. The bench raises a low-index ready bit while an offload is partway through its sequence and the consumer is stalling on a fixed pattern. The scoreboard then requires that the new task is issued right after the fetch of the offload in flight, before any higher-index task that was waiting, and that no completed task is ever issued again.

// File: rtl/ko_pkg.sv
package ko_pkg;
  typedef enum logic [1:0] {
    OP_HOST  = 2'd0,
    OP_CFG   = 2'd1,
    OP_SEND  = 2'd2,
    OP_FETCH = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOST,
    S_CFG,
    S_SEND,
    S_FETCH
  } state_e;
endpackage

// File: rtl/ko_pick.sv
module ko_pick #(
  parameter int N    = 32,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/ko_cost.sv
module ko_cost #(
  parameter int TW        = 32,
  parameter int NUM_UNITS = 2,
  parameter int KW        = 2,
  parameter int UW        = 1
) (
  input  logic [TW-1:0]           t_host_i,
  input  logic [TW-1:0]           t_acc_i,
  input  logic [TW-1:0]           t_cfg_i,
  input  logic [TW-1:0]           t_comm_i,
  input  logic [KW-1:0]           kernel_i,
  input  logic [NUM_UNITS*KW-1:0] unit_kernel_i,
  input  logic [UW-1:0]           victim_i,
  output logic                    offload_o,
  output logic                    resident_o,
  output logic [UW-1:0]           unit_o
);
  localparam int SW = TW + 2;

  logic [NUM_UNITS-1:0] hit;
  logic [SW-1:0]        sum;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hit
    assign hit[u] = (unit_kernel_i[u*KW +: KW] == kernel_i);
  end

  always_comb begin
    unit_o = victim_i;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (hit[u]) unit_o = UW'(u);
    end
  end

  assign resident_o = |hit;
  assign sum = SW'(t_acc_i) + SW'(t_comm_i) + (resident_o ? '0 : SW'(t_cfg_i));
  assign offload_o = SW'(t_host_i) > sum;
endmodule

// File: rtl/ko_offload_arbiter.sv
module ko_offload_arbiter
  import ko_pkg::*;
#(
  parameter int NUM_TASKS   = 32,
  parameter int NUM_KERNELS = 4,
  parameter int NUM_UNITS   = 2,
  parameter int TW          = 32,
  parameter int CW          = 16,
  localparam int TIDW = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int KW   = (NUM_KERNELS > 1) ? $clog2(NUM_KERNELS) : 1,
  localparam int UW   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_TASKS-1:0]      ready_mask_i,
  input  logic [NUM_TASKS*KW-1:0]   task_kernel_i,
  input  logic [NUM_UNITS*KW-1:0]   unit_kernel_i,
  input  logic [NUM_KERNELS*TW-1:0] t_host_i,
  input  logic [NUM_KERNELS*TW-1:0] t_acc_i,
  input  logic [NUM_KERNELS*TW-1:0] t_cfg_i,
  input  logic [NUM_KERNELS*TW-1:0] t_comm_i,
  output logic                      cmd_valid_o,
  input  logic                      cmd_ready_i,
  output logic [1:0]                cmd_op_o,
  output logic [TIDW-1:0]           cmd_task_o,
  output logic [UW-1:0]             cmd_unit_o,
  output logic [KW-1:0]             cmd_kernel_o,
  output logic                      offload_o,
  output logic                      reconf_o,
  output logic [CW-1:0]             host_cnt_o,
  output logic [CW-1:0]             offload_cnt_o
);
  state_e               state_q;
  logic [NUM_TASKS-1:0] done_q, eligible;
  logic [TIDW-1:0]      task_q, pick_idx;
  logic [KW-1:0]        kern_q, pick_kern;
  logic [UW-1:0]        unit_q, victim_q, cost_unit;
  logic                 off_q, cfg_q, pick_any, cost_off, cost_res, fire;
  logic [CW-1:0]        host_cnt_q, off_cnt_q;

  assign eligible  = ready_mask_i & ~done_q;
  assign pick_kern = task_kernel_i[int'(pick_idx)*KW +: KW];

  ko_pick #(.N(NUM_TASKS), .IDXW(TIDW)) u_pick (
    .req_i(eligible),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  ko_cost #(.TW(TW), .NUM_UNITS(NUM_UNITS), .KW(KW), .UW(UW)) u_cost (
    .t_host_i     (t_host_i[int'(pick_kern)*TW +: TW]),
    .t_acc_i      (t_acc_i[int'(pick_kern)*TW +: TW]),
    .t_cfg_i      (t_cfg_i[int'(pick_kern)*TW +: TW]),
    .t_comm_i     (t_comm_i[int'(pick_kern)*TW +: TW]),
    .kernel_i     (pick_kern),
    .unit_kernel_i(unit_kernel_i),
    .victim_i     (victim_q),
    .offload_o    (cost_off),
    .resident_o   (cost_res),
    .unit_o       (cost_unit)
  );

  assign cmd_valid_o = (state_q != S_IDLE);
  assign fire        = cmd_valid_o & cmd_ready_i;

  always_comb begin
    unique case (state_q)
      S_CFG:   cmd_op_o = OP_CFG;
      S_SEND:  cmd_op_o = OP_SEND;
      S_FETCH: cmd_op_o = OP_FETCH;
      default: cmd_op_o = OP_HOST;
    endcase
  end

  assign cmd_task_o    = task_q;
  assign cmd_unit_o    = unit_q;
  assign cmd_kernel_o  = kern_q;
  assign offload_o     = off_q;
  assign reconf_o      = cfg_q;
  assign host_cnt_o    = host_cnt_q;
  assign offload_cnt_o = off_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      done_q     <= '0;
      task_q     <= '0;
      kern_q     <= '0;
      unit_q     <= '0;
      victim_q   <= '0;
      off_q      <= 1'b0;
      cfg_q      <= 1'b0;
      host_cnt_q <= '0;
      off_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (pick_any) begin
          task_q <= pick_idx;
          kern_q <= pick_kern;
          unit_q <= cost_unit;
          off_q  <= cost_off;
          cfg_q  <= cost_off & ~cost_res;
          if (!cost_off)     state_q <= S_HOST;
          else if (!cost_res) state_q <= S_CFG;
          else               state_q <= S_SEND;
        end
        S_HOST: if (fire) begin
          done_q[task_q] <= 1'b1;
          host_cnt_q     <= host_cnt_q + CW'(1);
          state_q        <= S_IDLE;
        end
        S_CFG: if (fire) begin
          victim_q <= (victim_q == UW'(NUM_UNITS - 1)) ? '0 : victim_q + UW'(1);
          state_q  <= S_SEND;
        end
        S_SEND: if (fire) state_q <= S_FETCH;
        S_FETCH: if (fire) begin
          done_q[task_q] <= 1'b1;
          off_cnt_q      <= off_cnt_q + CW'(1);
          state_q        <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r2_lowest_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && pick_any) |->
      (eligible[pick_idx] &&
       ((eligible & ((NUM_TASKS'(1) << pick_idx) - NUM_TASKS'(1))) == '0)));

  a_r1_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !done_q[cmd_task_o]);

  a_r6_send_after_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_op_o == OP_CFG) |=>
      (cmd_valid_o && cmd_op_o == OP_SEND && $stable(cmd_task_o) && $stable(cmd_unit_o)));

  a_r6_fetch_after_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_op_o == OP_SEND) |=>
      (cmd_valid_o && cmd_op_o == OP_FETCH && $stable(cmd_task_o) && $stable(cmd_unit_o)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_task_o) && $stable(cmd_unit_o)));

  a_r9_host_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_op_o == OP_HOST) |=> (host_cnt_o == $past(host_cnt_o) + CW'(1)));

  a_r9_offload_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_op_o == OP_FETCH) |=> (offload_cnt_o == $past(offload_cnt_o) + CW'(1)));
endmodule

// File: tb/tb_ko_offload_arbiter.sv
module tb_ko_offload_arbiter;
  localparam int NT = 32, NK = 4, NU = 2, TW = 32, CW = 16;
  localparam int KW = 2, UW = 1, TIDW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0]    ready_mask = '0;
  logic [NT*KW-1:0] task_kernel = '0;
  logic [NU*KW-1:0] unit_kernel = '0;
  logic [NK*TW-1:0] t_host = '0, t_acc = '0, t_cfg = '0, t_comm = '0;
  logic             cmd_valid, cmd_ready = 1'b0, offload, reconf;
  logic [1:0]       cmd_op;
  logic [TIDW-1:0]  cmd_task;
  logic [UW-1:0]    cmd_unit;
  logic [KW-1:0]    cmd_kernel;
  logic [CW-1:0]    host_cnt, off_cnt;

  ko_offload_arbiter #(.NUM_TASKS(NT), .NUM_KERNELS(NK), .NUM_UNITS(NU), .TW(TW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ready_mask_i(ready_mask), .task_kernel_i(task_kernel),
    .unit_kernel_i(unit_kernel), .t_host_i(t_host), .t_acc_i(t_acc), .t_cfg_i(t_cfg),
    .t_comm_i(t_comm), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_task_o(cmd_task), .cmd_unit_o(cmd_unit), .cmd_kernel_o(cmd_kernel),
    .offload_o(offload), .reconf_o(reconf), .host_cnt_o(host_cnt), .offload_cnt_o(off_cnt)
  );

  int checks = 0, errors = 0;
  int q_op[$], q_task[$], q_unit[$], q_chku[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int op, input int tsk, input int unit, input int chku, input string tag);
    q_op.push_back(op); q_task.push_back(tsk); q_unit.push_back(unit);
    q_chku.push_back(chku); q_tag.push_back(tag);
  endtask

  task automatic set_kernel_times(input int k, input logic [31:0] h, a, c, m);
    t_host[k*TW +: TW] = h; t_acc[k*TW +: TW] = a;
    t_cfg[k*TW +: TW] = c;  t_comm[k*TW +: TW] = m;
  endtask

  task automatic map_task(input int tsk, input int k);
    task_kernel[tsk*KW +: KW] = KW'(k);
  endtask

  task automatic set_units(input int u0, input int u1);
    unit_kernel = {KW'(u1), KW'(u0)};
  endtask

  task automatic drain();
    do @(negedge clk); while (q_op.size() != 0 || cmd_valid);
    repeat (3) @(negedge clk);
  endtask

  // consumer with a fixed stall pattern
  int cyc = 0;
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    cmd_ready = (cyc % 3 != 0) && (cyc % 11 != 5);
  end

  // monitor / scoreboard
  logic       prev_stall = 1'b0;
  logic [1:0] prev_op;
  logic [TIDW-1:0] prev_task;
  logic [UW-1:0]   prev_unit;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(cmd_valid && cmd_op == prev_op && cmd_task == prev_task && cmd_unit == prev_unit,
              "R8 hold", int'(cmd_task), int'(prev_task));
      if (cmd_valid && cmd_ready) begin
        if (q_op.size() == 0) begin
          check(1'b0, "R1 unexpected command", int'(cmd_task), -1);
        end else begin
          check(int'(cmd_op) == q_op[0], {q_tag[0], " op"}, int'(cmd_op), q_op[0]);
          check(int'(cmd_task) == q_task[0], {q_tag[0], " task"}, int'(cmd_task), q_task[0]);
          if (q_chku[0] != 0)
            check(int'(cmd_unit) == q_unit[0], {q_tag[0], " unit"}, int'(cmd_unit), q_unit[0]);
          void'(q_op.pop_front()); void'(q_task.pop_front()); void'(q_unit.pop_front());
          void'(q_chku.pop_front()); void'(q_tag.pop_front());
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_op = cmd_op; prev_task = cmd_task; prev_unit = cmd_unit;
    end
  end

  bit timed_out = 0;

  initial begin
    set_kernel_times(0, 10, 2, 5, 2);
    set_kernel_times(1, 8, 2, 5, 1);
    set_kernel_times(2, 1, 2, 5, 2);
    set_kernel_times(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    map_task(3, 1); map_task(5, 0); map_task(9, 2); map_task(1, 2);
    map_task(12, 0); map_task(20, 1); map_task(31, 3); map_task(21, 1);
    map_task(22, 0); map_task(23, 0); map_task(24, 0); map_task(7, 0);
    set_units(0, 2);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    fork
      begin
        @(negedge clk);
        check(!cmd_valid, "R10 valid after reset", int'(cmd_valid), 0);
        check(host_cnt == 0 && off_cnt == 0, "R10 counters after reset", int'(host_cnt + off_cnt), 0);
        repeat (5) @(negedge clk);
        check(!cmd_valid, "R1 no ready no command", int'(cmd_valid), 0);

        // phase A: units hold k0,k2
        push(0, 3, 0, 0, "R4 equal cost host");
        push(2, 5, 0, 1, "R3 resident send");
        push(3, 5, 0, 1, "R6 fetch");
        push(0, 1, 0, 0, "R2 late low index first");
        push(0, 9, 0, 0, "R5 host run");
        @(posedge clk); #1 ready_mask = (1 << 3) | (1 << 5) | (1 << 9);
        do @(negedge clk); while (!(cmd_valid && cmd_op == 2'd2));
        @(posedge clk); #1 ready_mask[1] = 1'b1;
        drain();
        check(host_cnt == 3, "R9 host count A", int'(host_cnt), 3);
        check(off_cnt == 1, "R9 offload count A", int'(off_cnt), 1);

        // phase B: no unit holds k0/k1
        set_units(2, 2);
        push(1, 12, 0, 1, "R7 victim unit0 cfg");
        push(2, 12, 0, 1, "R6 send after cfg");
        push(3, 12, 0, 1, "R6 fetch after send");
        push(0, 20, 0, 0, "R4 equal cost with cfg host");
        push(0, 31, 0, 0, "R4 no wrap host");
        @(posedge clk); #1 ready_mask |= (1 << 12) | (1 << 20) | (1 << 31);
        drain();

        set_units(2, 1);
        push(2, 21, 1, 1, "R3 resident unit1");
        push(3, 21, 1, 1, "R3 resident fetch");
        @(posedge clk); #1 ready_mask[21] = 1'b1;
        drain();

        set_units(0, 0);
        push(2, 22, 0, 1, "R3 lowest matching unit");
        push(3, 22, 0, 1, "R3 lowest matching fetch");
        @(posedge clk); #1 ready_mask[22] = 1'b1;
        drain();

        set_units(2, 2);
        push(1, 23, 1, 1, "R7 victim unit1");
        push(2, 23, 1, 1, "R6 send");
        push(3, 23, 1, 1, "R6 fetch");
        push(1, 24, 0, 1, "R7 victim wrap");
        push(2, 24, 0, 1, "R6 send");
        push(3, 24, 0, 1, "R6 fetch");
        @(posedge clk); #1 ready_mask |= (1 << 23) | (1 << 24);
        drain();

        check(host_cnt == 5, "R9 host count final", int'(host_cnt), 5);
        check(off_cnt == 6, "R9 offload count final", int'(off_cnt), 6);
        repeat (20) @(negedge clk);
        check(!cmd_valid, "R1 completed tasks not reissued", int'(cmd_valid), 0);
        check(q_op.size() == 0, "R6 missing commands", q_op.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule